// File: doc/BRIEF.md
# Demand-Filled Register Cache

The block is a small, fast register file that holds the registers of one thread context. Behind it sits a larger store that keeps every context's registers. Each result a core retires is written into both the fast file and the store, at the slot for the current context. A context switch therefore saves nothing and restores nothing. It clears one flag per fast-file register and moves a base pointer, and all of this completes in a single cycle.

Reads come from two ports. They are served combinationally from the fast file when both addressed registers are flagged present. When a read touches a register whose flag is clear, the block raises `stall` and copies that register from the store into the fast file. Only then does the read complete. If both operands are missing, port A's register is fetched first and port B's second.

Besides loading an absolute context number, the base pointer can be stepped up or down by one context. This lets the same mechanism serve as a register window for call and return. Each step also clears all presence flags.

Top module: `regcache_top`

## Requirements
- R1: After reset the base pointer selects context 0 and every presence flag is clear, so the first read of any register stalls; `stall` is low while `rd_req` is low.
- R2: When both addressed registers are present, `stall` stays low and `rd_a_data`/`rd_b_data` show the stored values in the same cycle.
- R3: A write (`wr_en`) updates the fast file and the store entry at base + `wr_idx`, and sets that register's presence flag.
- R4: A read that misses holds `stall` high for exactly 2 cycles per missing register: 2 cycles when one distinct register is missing (including A and B addressing the same register) and 4 cycles when two distinct registers are missing. Port A is filled before port B.
- R5: A completed fill sets the register's presence flag, so an immediate re-read of the same registers does not stall.
- R6: `sw_req` sets the base to `sw_ctx` × 32 and clears all presence flags in one cycle. Later reads return that context's values.
- R7: `call_req` adds 32 to the base and `ret_req` subtracts 32, both modulo 256, and both clear all presence flags. When several are raised together, `sw_req` wins over `call_req`, which wins over `ret_req`.
- R8: A write in the same cycle as a switch, call or return lands in the store at the old base.
- R9: A write to a register whose fill is in flight supersedes the fill. The written value is kept and the fetched value is discarded.
- R10: Across any mix of writes, switches, calls and returns, every completed read returns the latest value written to that register in the selected context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request; hold with stable indices while `stall` is high |
| rd_a_idx | input | 5 | Register index, read port A |
| rd_b_idx | input | 5 | Register index, read port B |
| rd_a_data | output | 32 | Port A value, valid when `rd_req` is high and `stall` is low |
| rd_b_data | output | 32 | Port B value, valid when `rd_req` is high and `stall` is low |
| stall | output | 1 | A requested register is being fetched from the store |
| wr_en | input | 1 | Write retired result |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |
| sw_req | input | 1 | Load base from `sw_ctx` |
| sw_ctx | input | 3 | Context number for `sw_req` |
| call_req | input | 1 | Step base up one context |
| ret_req | input | 1 | Step base down one context |

## Verification
The bench measures the stall length for a hit, for one missing register, for two missing registers and for both ports addressing one missing register. A sequencer that dropped port B or filled a register twice would show a wrong cycle count. Directed cases cover a return that wraps below context 0, a switch and a call raised together, and a write issued in the same cycle as a switch. A base updated too early would put that write into the new context. A write raced against a fill of the same register is re-read after the fill slot passes; letting the stale store value win would overwrite the fresh data. Long random runs then compare every read against a per-context model.

// File: rtl/regcache_pkg.sv
package regcache_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_t;
endpackage

// File: rtl/regcache_valid.sv
module regcache_valid #(
  parameter int REGS = 32,
  parameter int RAW  = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            set_a_en,
  input  logic [RAW-1:0]  set_a_idx,
  input  logic            set_b_en,
  input  logic [RAW-1:0]  set_b_idx,
  input  logic [RAW-1:0]  sel_a,
  input  logic [RAW-1:0]  sel_b,
  output logic            hit_a,
  output logic            hit_b,
  output logic [REGS-1:0] vld_o
);
  logic [REGS-1:0] vld_q, vld_d;
  logic            vld_en;

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < REGS; i++) begin
      if ((set_a_en && set_a_idx == RAW'(i)) || (set_b_en && set_b_idx == RAW'(i)))
        vld_d[i] = 1'b1;
    end
    if (clr) vld_d = '0;
  end

  assign vld_en = clr | set_a_en | set_b_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (vld_en) vld_q <= vld_d;
  end

  // one selector per read port
  assign hit_a = vld_q[sel_a];
  assign hit_b = vld_q[sel_b];
  assign vld_o = vld_q;
endmodule

// File: rtl/regcache_fast.sv
module regcache_fast #(
  parameter int REGS = 32,
  parameter int DW   = 32,
  parameter int RAW  = $clog2(REGS)
) (
  input  logic           clk,
  input  logic           we_a,
  input  logic [RAW-1:0] waddr_a,
  input  logic [DW-1:0]  wdata_a,
  input  logic           we_b,
  input  logic [RAW-1:0] waddr_b,
  input  logic [DW-1:0]  wdata_b,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b
);
  logic [DW-1:0] regs_q [REGS];

  // port A (retired write) has priority over port B (fill)
  always_ff @(posedge clk) begin
    for (int i = 0; i < REGS; i++) begin
      if (we_a && waddr_a == RAW'(i))      regs_q[i] <= wdata_a;
      else if (we_b && waddr_b == RAW'(i)) regs_q[i] <= wdata_b;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/regcache_store.sv
module regcache_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a same-cycle write is not visible to this read
  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/regcache_fill.sv
module regcache_fill
  import regcache_pkg::*;
#(
  parameter int REGS = 32,
  parameter int RAW  = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            rd_req,
  input  logic            miss_a,
  input  logic            miss_b,
  input  logic [RAW-1:0]  idx_a,
  input  logic [RAW-1:0]  idx_b,
  input  logic [REGS-1:0] vld_i,
  input  logic            wr_en,
  input  logic [RAW-1:0]  wr_idx,
  output logic            issue,
  output logic [RAW-1:0]  issue_idx,
  output logic            commit,
  output logic [RAW-1:0]  pend_idx
);
  fill_st_t       st_q, st_d;
  logic [RAW-1:0] pend_q, pend_d;
  logic           st_en;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    issue     = 1'b0;
    issue_idx = miss_a ? idx_a : idx_b;
    case (st_q)
      FS_IDLE: begin
        if (rd_req && (miss_a || miss_b)) begin
          issue  = 1'b1;
          pend_d = issue_idx;
          st_d   = FS_FILL;
        end
      end
      FS_FILL: st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
    if (abort) begin
      issue = 1'b0;
      st_d  = FS_IDLE;
    end
  end

  assign st_en = (st_d != st_q) | issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      pend_q <= '0;
    end else if (st_en) begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // drop the fill if the register became present or is written now
  assign commit   = (st_q == FS_FILL) && !abort && !vld_i[pend_q] &&
                    !(wr_en && wr_idx == pend_q);
  assign pend_idx = pend_q;
endmodule

// File: rtl/regcache_top.sv
module regcache_top #(
  parameter int CTXS = 8,
  parameter int REGS = 32,
  parameter int DW   = 32,
  localparam int RAW = $clog2(REGS),
  localparam int CAW = $clog2(CTXS),
  localparam int SAW = CAW + RAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_req,
  input  logic [RAW-1:0] rd_a_idx,
  input  logic [RAW-1:0] rd_b_idx,
  output logic [DW-1:0]  rd_a_data,
  output logic [DW-1:0]  rd_b_data,
  output logic           stall,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           sw_req,
  input  logic [CAW-1:0] sw_ctx,
  input  logic           call_req,
  input  logic           ret_req
);
  localparam logic [SAW-1:0] STEP = SAW'(REGS);

  logic [SAW-1:0]  base_q, base_d;
  logic            ctx_evt;
  logic            hit_a, hit_b;
  logic [REGS-1:0] vld;
  logic            issue, commit;
  logic [RAW-1:0]  issue_idx, pend_idx;
  logic [DW-1:0]   fill_data;

  assign ctx_evt = sw_req | call_req | ret_req;

  always_comb begin
    base_d = base_q;
    if (sw_req)        base_d = {sw_ctx, {RAW{1'b0}}};
    else if (call_req) base_d = base_q + STEP;
    else if (ret_req)  base_d = base_q - STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (ctx_evt) base_q <= base_d;
  end

  regcache_valid #(.REGS(REGS)) u_valid (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctx_evt),
    .set_a_en  (wr_en),
    .set_a_idx (wr_idx),
    .set_b_en  (commit),
    .set_b_idx (pend_idx),
    .sel_a     (rd_a_idx),
    .sel_b     (rd_b_idx),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .vld_o     (vld)
  );

  regcache_fill #(.REGS(REGS)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (ctx_evt),
    .rd_req    (rd_req),
    .miss_a    (!hit_a),
    .miss_b    (!hit_b),
    .idx_a     (rd_a_idx),
    .idx_b     (rd_b_idx),
    .vld_i     (vld),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .issue     (issue),
    .issue_idx (issue_idx),
    .commit    (commit),
    .pend_idx  (pend_idx)
  );

  regcache_store #(.DEPTH(CTXS * REGS), .DW(DW)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (base_q + SAW'(wr_idx)),
    .wdata   (wr_data),
    .re      (issue),
    .raddr   (base_q + SAW'(issue_idx)),
    .rdata_q (fill_data)
  );

  regcache_fast #(.REGS(REGS), .DW(DW)) u_fast (
    .clk     (clk),
    .we_a    (wr_en),
    .waddr_a (wr_idx),
    .wdata_a (wr_data),
    .we_b    (commit),
    .waddr_b (pend_idx),
    .wdata_b (fill_data),
    .raddr_a (rd_a_idx),
    .raddr_b (rd_b_idx),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data)
  );

  assign stall = rd_req & (!hit_a | !hit_b);
endmodule

// File: rtl/regcache_chk.sv
module regcache_chk #(
  parameter int CTXS = 8,
  parameter int REGS = 32,
  localparam int RAW = $clog2(REGS),
  localparam int CAW = $clog2(CTXS),
  localparam int SAW = CAW + RAW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            stall,
  input logic            wr_en,
  input logic [RAW-1:0]  wr_idx,
  input logic            sw_req,
  input logic [CAW-1:0]  sw_ctx,
  input logic            call_req,
  input logic            ret_req,
  input logic [SAW-1:0]  base_q,
  input logic [REGS-1:0] vld
);
  localparam logic [SAW-1:0] STEP = SAW'(REGS);

  // R6
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req || call_req || ret_req) |=> (vld == '0));

  // R3
  write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_req && !call_req && !ret_req) |=> vld[$past(wr_idx)]);

  // R6
  switch_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> (base_q == {$past(sw_ctx), {RAW{1'b0}}}));

  // R7
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && call_req) |=> (base_q == $past(base_q) + STEP));

  // R7
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && !call_req && ret_req) |=> (base_q == $past(base_q) - STEP));

  // R7
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && !call_req && !ret_req) |=> $stable(base_q));

  // R1
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> rd_req);
endmodule

bind regcache_top regcache_chk #(.CTXS(CTXS), .REGS(REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .stall    (stall),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .sw_req   (sw_req),
  .sw_ctx   (sw_ctx),
  .call_req (call_req),
  .ret_req  (ret_req),
  .base_q   (base_q),
  .vld      (vld)
);

// File: tb/test_regcache_top.sv
module test_regcache_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req;
  logic [4:0]  rd_a_idx, rd_b_idx;
  logic [31:0] rd_a_data, rd_b_data;
  logic        stall;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        sw_req;
  logic [2:0]  sw_ctx;
  logic        call_req, ret_req;

  int          n_chk  = 0;
  int          n_fail = 0;
  logic [31:0] ref_mem [256];
  int          base   = 0;

  always #2 clk = ~clk;

  regcache_top i_regcache_top (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_a_idx(rd_a_idx),
    .rd_b_idx(rd_b_idx), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .stall(stall), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sw_req(sw_req), .sw_ctx(sw_ctx), .call_req(call_req), .ret_req(ret_req)
  );

  function automatic int slot(int b, int r);
    return (b + r) % 256;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one read; exp_st < 0 means stall length not checked
  task automatic do_read(int a, int b, int exp_st, bit chk_data, string req);
    int n = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_a_idx = 5'(a); rd_b_idx = 5'(b);
    #1;
    while (stall && n < 20) begin
      n++;
      @(negedge clk); #1;
    end
    if (exp_st >= 0) check({req, " stall cycles"}, 32'(n), 32'(exp_st));
    if (chk_data) begin
      check({req, " port A"}, rd_a_data, ref_mem[slot(base, a)]);
      check({req, " port B"}, rd_b_data, ref_mem[slot(base, b)]);
    end
    rd_req = 1'b0;
  endtask

  // write and/or context event in one cycle
  task automatic do_op(bit w, int wi, logic [31:0] wd, bit sw, int ctx, bit cl, bit rt);
    @(negedge clk);
    wr_en = w; wr_idx = 5'(wi); wr_data = wd;
    sw_req = sw; sw_ctx = 3'(ctx); call_req = cl; ret_req = rt;
    if (w) ref_mem[slot(base, wi)] = wd;
    if (sw)      base = ctx * 32;
    else if (cl) base = (base + 32) % 256;
    else if (rt) base = (base + 256 - 32) % 256;
    @(negedge clk);
    wr_en = 1'b0; sw_req = 1'b0; call_req = 1'b0; ret_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; rd_req = 1'b0; rd_a_idx = '0; rd_b_idx = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    sw_req = 1'b0; sw_ctx = '0; call_req = 1'b0; ret_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle stall low, first read misses (2 cycles)
    #1 check("R1 idle stall", 32'(stall), 32'd0);
    do_read(0, 0, 2, 1'b0, "R1 first read after reset");

    // preload every context; R8 style ordering via do_op
    for (int c = 0; c < 8; c++) begin
      do_op(1'b0, 0, '0, 1'b1, c, 1'b0, 1'b0);
      for (int r = 0; r < 32; r++) do_op(1'b1, r, $urandom, 1'b0, 0, 1'b0, 1'b0);
    end

    // R2/R3: context 7 fully written, all present
    do_read(1, 2, 0, 1'b1, "R2 R3 hit after write");
    do_read(31, 0, 0, 1'b1, "R2 hit");

    // R6/R4/R5
    do_op(1'b0, 0, '0, 1'b1, 2, 1'b0, 1'b0);
    do_read(4, 4, 2, 1'b1, "R6 R4 same reg miss");
    do_read(4, 9, 2, 1'b1, "R4 port B miss");
    do_read(10, 11, 4, 1'b1, "R4 double miss");
    do_read(10, 11, 0, 1'b1, "R5 refill hit");

    // R7: call, return, wrap
    do_op(1'b0, 0, '0, 1'b0, 0, 1'b1, 1'b0);
    do_read(0, 31, 4, 1'b1, "R7 after call");
    do_op(1'b0, 0, '0, 1'b0, 0, 1'b0, 1'b1);
    do_read(10, 11, 4, 1'b1, "R7 after return");
    do_op(1'b0, 0, '0, 1'b1, 0, 1'b0, 1'b0);
    do_op(1'b0, 0, '0, 1'b0, 0, 1'b0, 1'b1);
    do_read(5, 6, 4, 1'b1, "R7 return wraps");
    do_op(1'b0, 0, '0, 1'b1, 5, 1'b1, 1'b1);
    do_read(3, 8, 4, 1'b1, "R7 switch priority");

    // R8: write with switch lands in old context
    do_op(1'b1, 3, 32'hC0DE_0008, 1'b1, 1, 1'b0, 1'b0);
    do_read(3, 3, 2, 1'b1, "R8 new context untouched");
    do_op(1'b0, 0, '0, 1'b1, 5, 1'b0, 1'b0);
    do_read(3, 3, 2, 1'b1, "R8 old context written");

    // R9: write racing a fill of the same register
    do_op(1'b0, 0, '0, 1'b1, 6, 1'b0, 1'b0);
    @(negedge clk);
    rd_req = 1'b1; rd_a_idx = 5'd7; rd_b_idx = 5'd7;
    wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'hFEED_0009;
    ref_mem[slot(base, 7)] = 32'hFEED_0009;
    #1 check("R9 miss stalls", 32'(stall), 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 stall after write", 32'(stall), 32'd0);
    check("R9 write value", rd_a_data, 32'hFEED_0009);
    @(negedge clk); #1;
    check("R9 fill discarded", rd_a_data, 32'hFEED_0009);
    rd_req = 1'b0;

    // R10: random mix against the model
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = int'($urandom % 12);
      case (op)
        0:       do_op(1'b0, 0, '0, 1'b1, int'($urandom % 8), 1'b0, 1'b0);
        1:       do_op(1'b0, 0, '0, 1'b0, 0, 1'b1, 1'b0);
        2:       do_op(1'b0, 0, '0, 1'b0, 0, 1'b0, 1'b1);
        3:       do_op(1'b1, int'($urandom % 32), $urandom, 1'b1,
                       int'($urandom % 8), 1'b0, 1'b0);
        4, 5, 6: do_op(1'b1, int'($urandom % 32), $urandom, 1'b0, 0, 1'b0, 1'b0);
        default: do_read(int'($urandom % 32), int'($urandom % 32), -1, 1'b1,
                         "R10 random read");
      endcase
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule